// File: doc/BRIEF.md
# Packed Vector Arithmetic Right Shifter

This datapath unit takes a packed vector of up to 256 bits and shifts every lane right by one shared count. Vacated high-order bits in each lane take a copy of that lane's original sign bit. Lanes are either 16 or 32 bits wide. The count comes from one of two places: the low half of a 128-bit vector value, or an unsigned 8-bit immediate. A count larger than the lane can hold fills each lane entirely with its sign.

A width select limits the operation to the low 64 bits, the low 128 bits or the full 256 bits. In 128-bit operation, a mode flag sets what happens to result bits 255:128. They either carry the caller's previous destination contents unchanged or are forced to zero. The result is registered, so it appears one clock after the request, and a valid strobe follows the input strobe. The unit produces no flags or exceptions.

Top module: `sra_vec_unit`

## Requirements
- R1: With `lane32`=0 (16-bit lanes), each lane of the result equals that lane shifted right by the count. Bits vacated at the top are filled with the lane's original bit 15.
- R2: With `lane32`=1 (32-bit lanes), each lane of the result equals that lane shifted right by the count. Bits vacated at the top are filled with the lane's original bit 31.
- R3: A single count is applied to every active lane at once.
- R4: If the 64-bit count is greater than 15 for 16-bit lanes, or greater than 31 for 32-bit lanes, every bit of each lane becomes that lane's sign bit. This comparison uses all 64 count bits, so a count of 2^32+1 still saturates.
- R5: With `cnt_use_imm`=0, the count is `cnt_vec[63:0]` and `cnt_vec[127:64]` has no effect on the result.
- R6: With `cnt_use_imm`=1, the count is `cnt_imm`, read as an unsigned value from 0 to 255, and `cnt_vec` is ignored.
- R7: With `width_sel`=2'b00 (64-bit), only bits 63:0 are shifted, and result bits 255:64 are zero.
- R8: With `width_sel`=2'b01 (128-bit) and `zero_upper`=0, result bits 255:128 equal `old_upper`.
- R9: With `width_sel`=2'b01 and `zero_upper`=1, result bits 255:128 are zero.
- R10: With `width_sel`=2'b10 or 2'b11 (256-bit), all lanes across 255:0 are shifted, and `old_upper` and `zero_upper` have no effect.
- R11: When `in_valid` is high on a clock edge, the result appears on `out_vec` with `out_valid` high after that edge. When `in_valid` is low, `out_valid` drops on the next edge and `out_vec` holds its value.
- R12: A synchronous active-high `rst` clears `out_valid` and `out_vec` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| src_vec | input | 256 | Packed operand |
| lane32 | input | 1 | 0: 16-bit lanes, 1: 32-bit lanes |
| cnt_use_imm | input | 1 | 1: count from `cnt_imm`, 0: from `cnt_vec` |
| cnt_vec | input | 128 | Vector count source (low 64 bits used) |
| cnt_imm | input | 8 | Immediate count |
| width_sel | input | 2 | 00: 64-bit, 01: 128-bit, 1x: 256-bit |
| zero_upper | input | 1 | 128-bit mode: 1 clears bits 255:128, 0 keeps `old_upper` |
| old_upper | input | 128 | Previous destination bits 255:128 |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_vec | output | 256 | Shifted result |

## Verification
The bench targets counts at the lane edge: 0, 1, lane width minus one, lane width, and values whose only set bits lie above bit 31. A design that truncated the count before its saturation check would shift 2^32+1 by one instead of filling each lane with its sign. The bench uses negative and positive lanes side by side, so a logical shift, or a shift that lets bits leak across lane borders, produces visibly wrong patterns. Other directed cases target nonzero upper count bits, preservation against clearing in 128-bit mode, zeroing in 64-bit mode and output hold. These catch a unit that reads the wrong count half or mixes up the two upper-bit modes.

// File: rtl/sra_pkg.sv
package sra_pkg;
  typedef enum logic [1:0] {
    VW_64  = 2'b00,
    VW_128 = 2'b01,
    VW_256 = 2'b10
  } vwidth_e;

  localparam int unsigned CNT_W = 64;
  localparam int unsigned AMT_W = 6;
endpackage

// File: rtl/sra_count_sel.sv
module sra_count_sel #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned IMM_W = 8,
  parameter int unsigned AMT_W = 6
) (
  input  logic             use_imm,
  input  logic             lane32,
  input  logic [CNT_W-1:0] cnt_low,
  input  logic [IMM_W-1:0] cnt_imm,
  output logic [AMT_W-1:0] amt,
  output logic             sat
);
  logic [CNT_W-1:0] raw;
  logic [CNT_W-1:0] limit;

  always_comb begin
    raw   = use_imm ? CNT_W'(cnt_imm) : cnt_low;
    limit = lane32 ? CNT_W'(31) : CNT_W'(15);
    // full-width compare so large counts never wrap into a small shift
    sat   = (raw > limit);
    amt   = sat ? AMT_W'(limit + CNT_W'(1)) : raw[AMT_W-1:0];
  end
endmodule

// File: rtl/sra_slice.sv
module sra_slice #(
  parameter int unsigned SLICE_W = 32,
  parameter int unsigned AMT_W   = 6,
  localparam int unsigned HALF_W = SLICE_W / 2
) (
  input  logic [SLICE_W-1:0] din,
  input  logic               lane32,
  input  logic [AMT_W-1:0]   amt,
  output logic [SLICE_W-1:0] dout
);
  logic [SLICE_W-1:0] half_res;
  logic [SLICE_W-1:0] full_res;

  genvar h;
  generate
    for (h = 0; h < 2; h++) begin : g_half
      logic signed [HALF_W-1:0] hin;
      assign hin = din[h*HALF_W +: HALF_W];
      assign half_res[h*HALF_W +: HALF_W] = hin >>> amt;
    end
  endgenerate

  logic signed [SLICE_W-1:0] fin;
  assign fin      = din;
  assign full_res = fin >>> amt;
  assign dout     = lane32 ? full_res : half_res;
endmodule

// File: rtl/sra_vec_unit.sv
module sra_vec_unit #(
  parameter int unsigned VEC_W   = 256,
  parameter int unsigned LOW_W   = 128,
  parameter int unsigned NAR_W   = 64,
  parameter int unsigned SLICE_W = 32,
  parameter int unsigned IMM_W   = 8,
  localparam int unsigned NSLICE = VEC_W / SLICE_W,
  localparam int unsigned UP_W   = VEC_W - LOW_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [VEC_W-1:0]  src_vec,
  input  logic              lane32,
  input  logic              cnt_use_imm,
  input  logic [LOW_W-1:0]  cnt_vec,
  input  logic [IMM_W-1:0]  cnt_imm,
  input  logic [1:0]        width_sel,
  input  logic              zero_upper,
  input  logic [UP_W-1:0]   old_upper,
  output logic              out_valid,
  output logic [VEC_W-1:0]  out_vec
);
  import sra_pkg::*;

  logic [AMT_W-1:0] amt;
  logic             sat;
  logic [VEC_W-1:0] shifted;
  logic [VEC_W-1:0] merged;

  sra_count_sel #(.CNT_W(CNT_W), .IMM_W(IMM_W), .AMT_W(AMT_W)) u_cnt (
    .use_imm (cnt_use_imm),
    .lane32  (lane32),
    .cnt_low (cnt_vec[CNT_W-1:0]),
    .cnt_imm (cnt_imm),
    .amt     (amt),
    .sat     (sat)
  );

  genvar s;
  generate
    for (s = 0; s < NSLICE; s++) begin : g_slice
      sra_slice #(.SLICE_W(SLICE_W), .AMT_W(AMT_W)) u_slice (
        .din    (src_vec[s*SLICE_W +: SLICE_W]),
        .lane32 (lane32),
        .amt    (amt),
        .dout   (shifted[s*SLICE_W +: SLICE_W])
      );
    end
  endgenerate

  always_comb begin
    merged = shifted;
    case (width_sel)
      VW_64:   merged[VEC_W-1:NAR_W] = '0;
      VW_128:  merged[VEC_W-1:LOW_W] = zero_upper ? '0 : old_upper;
      default: merged = shifted;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_vec   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_vec <= merged;
    end
  end

  // R11: strobe timing and hold
  a_r11_valid_follow: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r11_valid_drop: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_vec));
  // R4: saturated word lane is all sign
  a_r4_sat_fill: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sat && !lane32) |=>
      (out_vec[15:0] == 16'h0000 || out_vec[15:0] == 16'hFFFF));
  // R2: top dword lane keeps its sign in 256-bit mode
  a_r2_sign_kept: assert property (@(posedge clk) disable iff (rst)
    (in_valid && lane32 && width_sel[1]) |=> (out_vec[VEC_W-1] == $past(src_vec[VEC_W-1])));
  // R5: upper count half ignored, zero low count leaves data unchanged
  a_r5_upper_cnt_ignored: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !cnt_use_imm && cnt_vec[LOW_W-1:CNT_W] != '0 &&
     cnt_vec[CNT_W-1:0] == '0 && width_sel[1]) |=> (out_vec == $past(src_vec)));
  // R7: 64-bit mode clears the rest
  a_r7_narrow_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && width_sel == VW_64) |=> (out_vec[VEC_W-1:NAR_W] == '0));
  // R8: preserve mode
  a_r8_keep_upper: assert property (@(posedge clk) disable iff (rst)
    (in_valid && width_sel == VW_128 && !zero_upper) |=>
      (out_vec[VEC_W-1:LOW_W] == $past(old_upper)));
  // R9: clear mode
  a_r9_clear_upper: assert property (@(posedge clk) disable iff (rst)
    (in_valid && width_sel == VW_128 && zero_upper) |=> (out_vec[VEC_W-1:LOW_W] == '0));
endmodule

// File: tb/sra_vec_unit_tb.sv
module sra_vec_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [255:0] src_vec;
  logic         lane32;
  logic         cnt_use_imm;
  logic [127:0] cnt_vec;
  logic [7:0]   cnt_imm;
  logic [1:0]   width_sel;
  logic         zero_upper;
  logic [127:0] old_upper;
  logic         out_valid;
  logic [255:0] out_vec;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sra_vec_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_vec(src_vec),
    .lane32(lane32), .cnt_use_imm(cnt_use_imm), .cnt_vec(cnt_vec),
    .cnt_imm(cnt_imm), .width_sel(width_sel), .zero_upper(zero_upper),
    .old_upper(old_upper), .out_valid(out_valid), .out_vec(out_vec)
  );

  localparam logic [255:0] PAT_A = {4{64'h8001_7FFE_C3A5_1234}};
  localparam logic [255:0] PAT_B = {4{64'hF000_000F_0FFF_FFF0}};
  localparam logic [255:0] PAT_C = {8{32'h8765_4321}};
  localparam logic [127:0] OLD_U = {4{32'hDEAD_BEEF}};

  function automatic logic [255:0] ref_model(logic dw, logic [63:0] c, logic [1:0] w,
                                             logic zu, logic [255:0] s, logic [127:0] old);
    logic [255:0] r;
    int L;
    int n;
    r = '0;
    L = dw ? 32 : 16;
    n = (w == 2'b00) ? 64 : (w == 2'b01) ? 128 : 256;
    for (int base = 0; base < n; base += L)
      for (int i = 0; i < L; i++)
        if (c < 64'(L - i)) r[base + i] = s[base + i + int'(c)];
        else                r[base + i] = s[base + L - 1];
    if (w == 2'b01 && !zu) r[255:128] = old;
    return r;
  endfunction

  task automatic check(string req, logic [255:0] act, logic [255:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_op(string req, logic dw, logic imm_sel, logic [127:0] cv,
                        logic [7:0] ci, logic [1:0] w, logic zu, logic [255:0] s,
                        logic [127:0] old);
    logic [63:0] c;
    @(negedge clk);
    in_valid = 1; lane32 = dw; cnt_use_imm = imm_sel; cnt_vec = cv; cnt_imm = ci;
    width_sel = w; zero_upper = zu; src_vec = s; old_upper = old;
    @(negedge clk);
    in_valid = 0;
    c = imm_sel ? 64'(ci) : cv[63:0];
    check(req, out_vec, ref_model(dw, c, w, zu, s, old));
    check({req, " valid"}, {255'd0, out_valid}, 256'd1);
  endtask

  task automatic t_reset;
    check("R12 out_vec", out_vec, '0);
    check("R12 out_valid", {255'd0, out_valid}, '0);
  endtask

  task automatic t_word_shifts;
    logic [63:0] cl[5] = '{64'd0, 64'd1, 64'd7, 64'd15, 64'd16};
    foreach (cl[k]) begin
      run_op("R1 R3 word", 0, 0, {64'h0, cl[k]}, 0, 2'b10, 0, PAT_A, OLD_U);
      run_op("R1 R3 word", 0, 0, {64'h0, cl[k]}, 0, 2'b10, 0, PAT_B, OLD_U);
    end
  endtask

  task automatic t_dword_shifts;
    logic [63:0] cl[5] = '{64'd0, 64'd1, 64'd13, 64'd31, 64'd32};
    foreach (cl[k]) begin
      run_op("R2 R3 dword", 1, 0, {64'h0, cl[k]}, 0, 2'b10, 0, PAT_C, OLD_U);
      run_op("R2 R3 dword", 1, 0, {64'h0, cl[k]}, 0, 2'b10, 0, PAT_B, OLD_U);
    end
  endtask

  task automatic t_saturate;
    run_op("R4 word 17", 0, 0, {64'h0, 64'd17}, 0, 2'b10, 0, PAT_A, OLD_U);
    run_op("R4 word 2^32+1", 0, 0, {64'h0, 64'h1_0000_0001}, 0, 2'b10, 0, PAT_A, OLD_U);
    run_op("R4 dword 2^32+1", 1, 0, {64'h0, 64'h1_0000_0001}, 0, 2'b10, 0, PAT_C, OLD_U);
    run_op("R4 dword max", 1, 0, {64'h0, 64'hFFFF_FFFF_FFFF_FFFF}, 0, 2'b10, 0, PAT_B, OLD_U);
    run_op("R4 word 2^40", 0, 0, {64'h0, 64'h100_0000_0000}, 0, 2'b10, 0, PAT_B, OLD_U);
  endtask

  task automatic t_count_upper;
    run_op("R5 upper ignored", 0, 0, {64'hFFFF_FFFF_FFFF_FFFF, 64'd3}, 0, 2'b10, 0, PAT_A, OLD_U);
    run_op("R5 upper ignored zero", 1, 0, {64'h0000_0001_0000_0000, 64'd0}, 0, 2'b10, 0, PAT_C, OLD_U);
  endtask

  task automatic t_immediate;
    run_op("R6 imm 5", 0, 1, {128{1'b1}}, 8'd5, 2'b10, 0, PAT_A, OLD_U);
    run_op("R6 imm 31", 1, 1, '0, 8'd31, 2'b10, 0, PAT_C, OLD_U);
    run_op("R6 imm 255", 1, 1, '0, 8'd255, 2'b10, 0, PAT_B, OLD_U);
    run_op("R6 imm 128", 0, 1, '0, 8'd128, 2'b10, 0, PAT_A, OLD_U);
  endtask

  task automatic t_widths;
    run_op("R7 narrow word", 0, 0, {64'h0, 64'd4}, 0, 2'b00, 0, PAT_A, OLD_U);
    run_op("R7 narrow dword", 1, 0, {64'h0, 64'd9}, 0, 2'b00, 1, PAT_C, OLD_U);
    run_op("R8 keep upper", 0, 0, {64'h0, 64'd2}, 0, 2'b01, 0, PAT_A, OLD_U);
    run_op("R9 clear upper", 1, 0, {64'h0, 64'd2}, 0, 2'b01, 1, PAT_C, OLD_U);
    run_op("R10 wide zu=1", 1, 1, '0, 8'd6, 2'b10, 1, PAT_C, OLD_U);
    run_op("R10 wide sel11", 0, 1, '0, 8'd3, 2'b11, 0, PAT_B, OLD_U);
  endtask

  task automatic t_hold;
    logic [255:0] last;
    run_op("R11 load", 0, 1, '0, 8'd1, 2'b10, 0, PAT_A, OLD_U);
    last = out_vec;
    @(negedge clk);
    src_vec = PAT_B; cnt_imm = 8'd9;
    @(negedge clk);
    check("R11 hold", out_vec, last);
    check("R11 valid low", {255'd0, out_valid}, '0);
  endtask

  initial begin
    rst = 1; in_valid = 0; src_vec = '0; lane32 = 0; cnt_use_imm = 0;
    cnt_vec = '0; cnt_imm = '0; width_sel = 2'b10; zero_upper = 0; old_upper = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 0;
    t_word_shifts();
    t_dword_shifts();
    t_saturate();
    t_count_upper();
    t_immediate();
    t_widths();
    t_hold();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule